// File: doc/BRIEF.md
# Lane-Banked Dual-Width Data FIFO

This block is the data buffer that sits between a register-bus data port and a serial shifter. Its storage is four byte-wide FIFO lanes working side by side. A 32-bit bus access pushes or pops one byte in every lane in the same cycle, so word traffic sees 64 bytes of room. An 8-bit bus access touches lane 0 only, so byte traffic sees 16 bytes of room. The shifter side moves exactly one byte per access. In word mode it walks the lanes in rotation, starting at lane 0, so the least significant byte of each word is always the first byte on the wire.

One instance can act as either a transmit or a receive buffer. For transmit, the bus pushes and the shifter pops. For receive, the shifter pushes and the bus pops. The `word_mode` input is set once per transaction to choose the width. An access through the port of the other width is refused. Level flags report full, half-full, empty, word-available and byte-available, each computed for the selected width. Any refused access produces a one-cycle error pulse. A synchronous soft clear drops all stored data.

Top module: `lane_banked_fifo`

## Requirements
- R1: After `rst`, or in the cycle after `soft_clr` is high, the block holds no data and the lane rotation points at lane 0. The outputs are then `flag_empty`=1 and `flag_full`=`flag_half`=`flag_word_avail`=`flag_byte_avail`=`err_access`=0, and every access presented during the clear cycle is ignored.
- R2: In word mode (`word_mode`=1), a bus word push writes bits [8i+7:8i] of `bus_wdata` into lane i. `bus_rdata` shows the head of lane i in the same bit positions, and a bus word pop removes one byte from every lane. Words come out in the order they were pushed.
- R3: In word mode the shifter pushes and pops cycle through the lanes in the order 0,1,2,3. After a word push, the first shifter byte out is bits [7:0]. Four shifter pushes form one word with the first byte in bits [7:0].
- R4: In byte mode (`word_mode`=0), only lane 0 is used. A bus byte push stores `bus_wdata[7:0]`, `bus_rdata` reads as {24'b0, head byte}, and 16 bytes can be stored.
- R5: Word-mode capacity is 64 bytes, that is 16 bus word pushes. A 17th push is refused.
- R6: In word mode, `flag_full` is 1 when any lane holds 16 bytes. In byte mode it is 1 when lane 0 holds 16 bytes.
- R7: In word mode, `flag_half` is 1 when at least 32 bytes are stored in total. In byte mode it is 1 when lane 0 holds at least 8 bytes.
- R8: `flag_word_avail` is 1 only in word mode, and only when every lane holds at least one byte. `flag_byte_avail` is 1 whenever at least one byte is stored.
- R9: `flag_empty` is 1 exactly when no lane holds a byte, meaning every queued byte has left.
- R10: A push into a lane that has no room, or a pop from a lane that is empty, changes no stored data. Such an access drives `err_access` high for exactly the one following cycle.
- R11: In word mode a bus byte access, and in byte mode a bus word access, is ignored and raises the `err_access` pulse.
- R12: A shifter push in the same cycle as a bus push is dropped and raises `err_access`, while the bus push proceeds. The same rule holds for a shifter pop against a bus pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_clr | input | 1 | Synchronous clear of all lanes and pointers |
| word_mode | input | 1 | 1 = 32-bit transaction, 0 = 8-bit transaction |
| bus_wr_word | input | 1 | Bus 32-bit push |
| bus_wr_byte | input | 1 | Bus 8-bit push |
| bus_wdata | input | 32 | Bus push data |
| bus_rd_word | input | 1 | Bus 32-bit pop |
| bus_rd_byte | input | 1 | Bus 8-bit pop |
| bus_rdata | output | 32 | Head data for bus pop |
| sh_push | input | 1 | Shifter byte push |
| sh_push_data | input | 8 | Shifter push byte |
| sh_pop | input | 1 | Shifter byte pop |
| sh_pop_data | output | 8 | Head byte for shifter pop |
| flag_full | output | 1 | No room at the selected width |
| flag_half | output | 1 | At least half of the selected capacity used |
| flag_empty | output | 1 | No bytes stored |
| flag_word_avail | output | 1 | A whole word can be popped |
| flag_byte_avail | output | 1 | At least one byte stored |
| err_access | output | 1 | One-cycle pulse after a refused access |

## Verification
The bound checker watches, on every cycle, the rules that depend only on the current flags and requests. These are: the error pulse after an overflow, an underflow, a wrong-width access or a conflict; empty staying empty under refused pops; the clear emptying the block; and the mutual consistency of the flags. Byte order across lanes, shifter rotation, exact capacity at each width and the half and full thresholds depend on the stored contents over many cycles, so only the bench's scenarios demonstrate them.

// File: rtl/lbf_pkg.sv
package lbf_pkg;

    localparam int BYTE_W = 8;

    // Requests arriving from the bus side and the shifter side in one cycle.
    typedef struct packed {
        logic wr_word;
        logic wr_byte;
        logic rd_word;
        logic rd_byte;
        logic sh_push;
        logic sh_pop;
    } access_t;

    // Per-lane command produced by the steering logic.
    typedef struct packed {
        logic              push;
        logic              pop;
        logic [BYTE_W-1:0] din;
    } lane_req_t;

    // Level status for the selected access width.
    typedef struct packed {
        logic full;
        logic half;
        logic empty;
        logic word_avail;
        logic byte_avail;
    } level_flags_t;

    function automatic logic any_access(input access_t a);
        return a.wr_word | a.wr_byte | a.rd_word | a.rd_byte | a.sh_push | a.sh_pop;
    endfunction

endpackage

// File: rtl/lbf_lane.sv
module lbf_lane
    import lbf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         clr,
    input  lane_req_t                    req,
    output logic [BYTE_W-1:0]            head,
    output logic [$clog2(DEPTH+1)-1:0]   count
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wptr_q;
    logic [PTR_W-1:0]  rptr_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (req.push) begin
            mem[wptr_q] <= req.din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (req.push) begin
                wptr_q <= ptr_inc(wptr_q);
            end
            if (req.pop) begin
                rptr_q <= ptr_inc(rptr_q);
            end
            cnt_q <= cnt_q + CNT_W'(req.push) - CNT_W'(req.pop);
        end
    end

    assign head  = mem[rptr_q];
    assign count = cnt_q;

endmodule

// File: rtl/lbf_steer.sv
module lbf_steer
    import lbf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          clr,
    input  logic                          word_mode,
    input  access_t                       acc,
    input  logic [LANES*BYTE_W-1:0]       bus_wdata,
    input  logic [BYTE_W-1:0]             sh_din,
    input  logic [$clog2(DEPTH+1)-1:0]    lane_cnt  [LANES],
    input  logic [BYTE_W-1:0]             lane_head [LANES],
    output lane_req_t                     lane_req  [LANES],
    output logic [LANES*BYTE_W-1:0]       bus_rdata,
    output logic [BYTE_W-1:0]             sh_dout,
    output logic                          illegal
);
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int LSEL_W = $clog2(LANES);

    logic [LANES-1:0]  l_full;
    logic [LANES-1:0]  l_empty;
    logic [LSEL_W-1:0] wr_sel_q;
    logic [LSEL_W-1:0] rd_sel_q;
    logic [LSEL_W-1:0] wr_lane;
    logic [LSEL_W-1:0] rd_lane;
    logic              bus_wr;
    logic              bus_rd;
    logic              bus_room;
    logic              bus_avail;
    logic              wrong_width;
    logic              bw_ok;
    logic              br_ok;
    logic              sp_ok;
    logic              so_ok;

    for (genvar g = 0; g < LANES; g++) begin : g_lvl
        assign l_full[g]  = (lane_cnt[g] == CNT_W'(DEPTH));
        assign l_empty[g] = (lane_cnt[g] == '0);
    end

    always_comb begin
        wr_lane     = word_mode ? wr_sel_q : '0;
        rd_lane     = word_mode ? rd_sel_q : '0;
        bus_wr      = word_mode ? acc.wr_word : acc.wr_byte;
        bus_rd      = word_mode ? acc.rd_word : acc.rd_byte;
        bus_room    = word_mode ? ~|l_full : ~l_full[0];
        bus_avail   = word_mode ? ~|l_empty : ~l_empty[0];
        wrong_width = word_mode ? (acc.wr_byte | acc.rd_byte)
                                : (acc.wr_word | acc.rd_word);

        bw_ok = !clr && bus_wr && bus_room;
        br_ok = !clr && bus_rd && bus_avail;
        sp_ok = !clr && acc.sh_push && !bus_wr && !l_full[wr_lane];
        so_ok = !clr && acc.sh_pop && !bus_rd && !l_empty[rd_lane];

        illegal = !clr && any_access(acc) &&
                  (wrong_width ||
                   (bus_wr && !bus_room) ||
                   (bus_rd && !bus_avail) ||
                   (acc.sh_push && (bus_wr || l_full[wr_lane])) ||
                   (acc.sh_pop && (bus_rd || l_empty[rd_lane])));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_req
        logic in_bus_set;
        assign in_bus_set = word_mode || (g == 0);

        always_comb begin
            lane_req[g].push = (bw_ok && in_bus_set) ||
                               (sp_ok && (wr_lane == LSEL_W'(g)));
            lane_req[g].pop  = (br_ok && in_bus_set) ||
                               (so_ok && (rd_lane == LSEL_W'(g)));
            lane_req[g].din  = bw_ok ? bus_wdata[g*BYTE_W +: BYTE_W] : sh_din;
        end

        assign bus_rdata[g*BYTE_W +: BYTE_W] = in_bus_set ? lane_head[g] : '0;
    end

    assign sh_dout = lane_head[rd_lane];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wr_sel_q <= '0;
            rd_sel_q <= '0;
        end else if (word_mode) begin
            if (sp_ok) begin
                wr_sel_q <= (wr_sel_q == LSEL_W'(LANES - 1)) ? '0 : wr_sel_q + 1'b1;
            end
            if (so_ok) begin
                rd_sel_q <= (rd_sel_q == LSEL_W'(LANES - 1)) ? '0 : rd_sel_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/lbf_flags.sv
module lbf_flags
    import lbf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                        word_mode,
    input  logic [$clog2(DEPTH+1)-1:0]  lane_cnt [LANES],
    output level_flags_t                flags
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int CAP   = LANES * DEPTH;
    localparam int TOT_W = $clog2(CAP + 1);

    logic [TOT_W-1:0] total;
    logic [LANES-1:0] l_full;
    logic [LANES-1:0] l_has;

    always_comb begin
        total = '0;
        for (int l = 0; l < LANES; l++) begin
            total    = total + TOT_W'(lane_cnt[l]);
            l_full[l] = (lane_cnt[l] == CNT_W'(DEPTH));
            l_has[l]  = (lane_cnt[l] != '0);
        end
    end

    always_comb begin
        if (word_mode) begin
            flags.full       = |l_full;
            flags.half       = (total >= TOT_W'(CAP / 2));
            flags.word_avail = &l_has;
        end else begin
            flags.full       = l_full[0];
            flags.half       = (lane_cnt[0] >= CNT_W'(DEPTH / 2));
            flags.word_avail = 1'b0;
        end
        flags.empty      = (total == '0);
        flags.byte_avail = (total != '0);
    end

endmodule

// File: rtl/lane_banked_fifo.sv
module lane_banked_fifo
    import lbf_pkg::*;
#(
    parameter int LANES = 4,
    parameter int DEPTH = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     soft_clr,
    input  logic                     word_mode,
    input  logic                     bus_wr_word,
    input  logic                     bus_wr_byte,
    input  logic [LANES*BYTE_W-1:0]  bus_wdata,
    input  logic                     bus_rd_word,
    input  logic                     bus_rd_byte,
    output logic [LANES*BYTE_W-1:0]  bus_rdata,
    input  logic                     sh_push,
    input  logic [BYTE_W-1:0]        sh_push_data,
    input  logic                     sh_pop,
    output logic [BYTE_W-1:0]        sh_pop_data,
    output logic                     flag_full,
    output logic                     flag_half,
    output logic                     flag_empty,
    output logic                     flag_word_avail,
    output logic                     flag_byte_avail,
    output logic                     err_access
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    access_t           acc;
    lane_req_t         lane_req  [LANES];
    logic [BYTE_W-1:0] lane_head [LANES];
    logic [CNT_W-1:0]  lane_cnt  [LANES];
    level_flags_t      flags;
    logic              illegal;
    logic              err_q;

    always_comb begin
        acc.wr_word = bus_wr_word;
        acc.wr_byte = bus_wr_byte;
        acc.rd_word = bus_rd_word;
        acc.rd_byte = bus_rd_byte;
        acc.sh_push = sh_push;
        acc.sh_pop  = sh_pop;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lbf_lane #(.DEPTH(DEPTH)) u_lane (
            .clk   (clk),
            .rst   (rst),
            .clr   (soft_clr),
            .req   (lane_req[g]),
            .head  (lane_head[g]),
            .count (lane_cnt[g])
        );
    end

    lbf_steer #(.LANES(LANES), .DEPTH(DEPTH)) u_steer (
        .clk       (clk),
        .rst       (rst),
        .clr       (soft_clr),
        .word_mode (word_mode),
        .acc       (acc),
        .bus_wdata (bus_wdata),
        .sh_din    (sh_push_data),
        .lane_cnt  (lane_cnt),
        .lane_head (lane_head),
        .lane_req  (lane_req),
        .bus_rdata (bus_rdata),
        .sh_dout   (sh_pop_data),
        .illegal   (illegal)
    );

    lbf_flags #(.LANES(LANES), .DEPTH(DEPTH)) u_flags (
        .word_mode (word_mode),
        .lane_cnt  (lane_cnt),
        .flags     (flags)
    );

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            err_q <= 1'b0;
        end else begin
            err_q <= illegal;
        end
    end

    assign flag_full       = flags.full;
    assign flag_half       = flags.half;
    assign flag_empty      = flags.empty;
    assign flag_word_avail = flags.word_avail;
    assign flag_byte_avail = flags.byte_avail;
    assign err_access      = err_q;

endmodule

// File: rtl/lane_banked_fifo_chk.sv
module lane_banked_fifo_chk (
    input logic clk,
    input logic rst,
    input logic soft_clr,
    input logic word_mode,
    input logic bus_wr_word,
    input logic bus_wr_byte,
    input logic bus_rd_word,
    input logic bus_rd_byte,
    input logic sh_push,
    input logic sh_pop,
    input logic flag_full,
    input logic flag_half,
    input logic flag_empty,
    input logic flag_word_avail,
    input logic flag_byte_avail,
    input logic err_access
);
    a_r1_clear_empties: assert property (@(posedge clk) disable iff (rst)
        soft_clr |=> (flag_empty && !err_access && !flag_full && !flag_byte_avail));

    a_r10_overflow_err: assert property (@(posedge clk) disable iff (rst)
        (word_mode && bus_wr_word && flag_full && !soft_clr) |=> err_access);

    a_r10_underflow_err: assert property (@(posedge clk) disable iff (rst)
        (flag_empty && (bus_rd_word || bus_rd_byte || sh_pop) && !soft_clr) |=> err_access);

    a_r10_empty_holds: assert property (@(posedge clk) disable iff (rst)
        (flag_empty && !bus_wr_word && !bus_wr_byte && !sh_push) |=> flag_empty);

    a_r11_wrong_width_word: assert property (@(posedge clk) disable iff (rst)
        (word_mode && (bus_wr_byte || bus_rd_byte) && !soft_clr) |=> err_access);

    a_r11_wrong_width_byte: assert property (@(posedge clk) disable iff (rst)
        (!word_mode && (bus_wr_word || bus_rd_word) && !soft_clr) |=> err_access);

    a_r12_push_conflict: assert property (@(posedge clk) disable iff (rst)
        (word_mode && bus_wr_word && sh_push && !soft_clr) |=> err_access);

    a_r8_word_implies_byte: assert property (@(posedge clk) disable iff (rst)
        flag_word_avail |-> flag_byte_avail);

    a_r8_no_word_in_byte_mode: assert property (@(posedge clk) disable iff (rst)
        !word_mode |-> !flag_word_avail);

    a_r9_empty_exclusive: assert property (@(posedge clk) disable iff (rst)
        flag_empty |-> (!flag_byte_avail && !flag_half && !flag_full));

endmodule

bind lane_banked_fifo lane_banked_fifo_chk u_chk (
    .clk             (clk),
    .rst             (rst),
    .soft_clr        (soft_clr),
    .word_mode       (word_mode),
    .bus_wr_word     (bus_wr_word),
    .bus_wr_byte     (bus_wr_byte),
    .bus_rd_word     (bus_rd_word),
    .bus_rd_byte     (bus_rd_byte),
    .sh_push         (sh_push),
    .sh_pop          (sh_pop),
    .flag_full       (flag_full),
    .flag_half       (flag_half),
    .flag_empty      (flag_empty),
    .flag_word_avail (flag_word_avail),
    .flag_byte_avail (flag_byte_avail),
    .err_access      (err_access)
);

// File: tb/test_lane_banked_fifo.sv
module test_lane_banked_fifo;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        soft_clr = 1'b0;
    logic        word_mode = 1'b1;
    logic        bus_wr_word = 1'b0;
    logic        bus_wr_byte = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd_word = 1'b0;
    logic        bus_rd_byte = 1'b0;
    logic [31:0] bus_rdata;
    logic        sh_push = 1'b0;
    logic [7:0]  sh_push_data = '0;
    logic        sh_pop = 1'b0;
    logic [7:0]  sh_pop_data;
    logic        flag_full, flag_half, flag_empty, flag_word_avail, flag_byte_avail;
    logic        err_access;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [31:0] cap_rd;
    logic [7:0]  cap_sh;

    always #2 clk = ~clk;

    lane_banked_fifo i_lane_banked_fifo (
        .clk(clk), .rst(rst), .soft_clr(soft_clr), .word_mode(word_mode),
        .bus_wr_word(bus_wr_word), .bus_wr_byte(bus_wr_byte), .bus_wdata(bus_wdata),
        .bus_rd_word(bus_rd_word), .bus_rd_byte(bus_rd_byte), .bus_rdata(bus_rdata),
        .sh_push(sh_push), .sh_push_data(sh_push_data), .sh_pop(sh_pop),
        .sh_pop_data(sh_pop_data), .flag_full(flag_full), .flag_half(flag_half),
        .flag_empty(flag_empty), .flag_word_avail(flag_word_avail),
        .flag_byte_avail(flag_byte_avail), .err_access(err_access)
    );

    // op codes used in the vector table
    localparam logic [2:0] OP_WW = 3'd1, OP_WB = 3'd2, OP_RW = 3'd3,
                           OP_RB = 3'd4, OP_SP = 3'd5, OP_SO = 3'd6;

    // access bits: {wr_word, wr_byte, rd_word, rd_byte, sh_push, sh_pop}
    localparam logic [5:0] A_WW = 6'b100000, A_WB = 6'b010000, A_RW = 6'b001000,
                           A_RB = 6'b000100, A_SP = 6'b000010, A_SO = 6'b000001;

    typedef struct packed {
        logic [2:0]  op;
        logic [31:0] wd;
        logic [7:0]  sd;
        logic [5:0]  exp;     // {full, half, empty, word_avail, byte_avail, err}
        logic        chk_rd;
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NVEC = 15;
    localparam vec_t VECS [NVEC] = '{
        '{OP_WW, 32'h44332211, 8'h00, 6'b000110, 1'b0, 32'h0},
        '{OP_WW, 32'h88776655, 8'h00, 6'b000110, 1'b0, 32'h0},
        '{OP_SO, 32'h0,        8'h00, 6'b000110, 1'b1, 32'h11},
        '{OP_SO, 32'h0,        8'h00, 6'b000110, 1'b1, 32'h22},
        '{OP_SO, 32'h0,        8'h00, 6'b000110, 1'b1, 32'h33},
        '{OP_SO, 32'h0,        8'h00, 6'b000110, 1'b1, 32'h44},
        '{OP_RW, 32'h0,        8'h00, 6'b001000, 1'b1, 32'h88776655},
        '{OP_RW, 32'h0,        8'h00, 6'b001001, 1'b0, 32'h0},
        '{OP_WB, 32'h000000EE, 8'h00, 6'b001001, 1'b0, 32'h0},
        '{OP_SP, 32'h0,        8'hA1, 6'b000010, 1'b0, 32'h0},
        '{OP_SP, 32'h0,        8'hB2, 6'b000010, 1'b0, 32'h0},
        '{OP_SP, 32'h0,        8'hC3, 6'b000010, 1'b0, 32'h0},
        '{OP_SP, 32'h0,        8'hD4, 6'b000110, 1'b0, 32'h0},
        '{OP_RW, 32'h0,        8'h00, 6'b001000, 1'b1, 32'hD4C3B2A1},
        '{OP_SO, 32'h0,        8'h00, 6'b001001, 1'b0, 32'h0}
    };

    function automatic logic [5:0] acc_of(input logic [2:0] op);
        case (op)
            OP_WW:   return A_WW;
            OP_WB:   return A_WB;
            OP_RW:   return A_RW;
            OP_RB:   return A_RB;
            OP_SP:   return A_SP;
            OP_SO:   return A_SO;
            default: return 6'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [5:0] flag_vec();
        return {flag_full, flag_half, flag_empty, flag_word_avail, flag_byte_avail, err_access};
    endfunction

    // Drive one cycle of accesses at a falling edge, capture the head data
    // before the rising edge, and return at the next falling edge with the
    // registered results visible.
    task automatic step(input logic wm, input logic [5:0] a,
                        input logic [31:0] wd, input logic [7:0] sd);
        @(negedge clk);
        word_mode = wm;
        {bus_wr_word, bus_wr_byte, bus_rd_word, bus_rd_byte, sh_push, sh_pop} = a;
        bus_wdata = wd;
        sh_push_data = sd;
        #1;
        cap_rd = bus_rdata;
        cap_sh = sh_pop_data;
        @(negedge clk);
        {bus_wr_word, bus_wr_byte, bus_rd_word, bus_rd_byte, sh_push, sh_pop} = '0;
    endtask

    task automatic do_clear(input logic wm);
        @(negedge clk);
        word_mode = wm;
        soft_clr = 1'b1;
        @(negedge clk);
        soft_clr = 1'b0;
    endtask

    initial begin : watchdog
        while (cycles < 50000) begin
            @(posedge clk);
            cycles++;
        end
        fails++;
        tests++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset flags", 32'(flag_vec()), 32'(6'b001000));

        // ---- vector table: word mode byte order, rotation, errors (R2 R3 R8 R9 R10 R11)
        for (int v = 0; v < NVEC; v++) begin
            step(1'b1, acc_of(VECS[v].op), VECS[v].wd, VECS[v].sd);
            check($sformatf("R2/R3/R8/R9/R10 vec %0d flags", v),
                  32'(flag_vec()), 32'(VECS[v].exp));
            if (VECS[v].chk_rd) begin
                if (VECS[v].op == OP_SO)
                    check($sformatf("R3 vec %0d shifter byte", v), 32'(cap_sh), VECS[v].exp_rd);
                else
                    check($sformatf("R2 vec %0d bus word", v), cap_rd, VECS[v].exp_rd);
            end
        end

        // ---- R10: error pulse lasts one cycle
        step(1'b1, A_RW, 32'h0, 8'h0);
        check("R10 error pulse raised", 32'(err_access), 32'd1);
        @(negedge clk);
        check("R10 error pulse dropped", 32'(err_access), 32'd0);

        // ---- R5 R6 R7: word capacity and thresholds
        do_clear(1'b1);
        for (int k = 1; k <= 16; k++) begin
            step(1'b1, A_WW, {8'(k + 48), 8'(k + 32), 8'(k + 16), 8'(k)}, 8'h0);
            check($sformatf("R7 half after %0d words", k), 32'(flag_half), 32'(k >= 8));
            check($sformatf("R6 full after %0d words", k), 32'(flag_full), 32'(k == 16));
        end
        step(1'b1, A_WW, 32'hDEADBEEF, 8'h0);
        check("R5 17th word push refused", 32'(err_access), 32'd1);
        for (int k = 1; k <= 16; k++) begin
            step(1'b1, A_RW, 32'h0, 8'h0);
            check($sformatf("R5 word %0d order", k), cap_rd,
                  {8'(k + 48), 8'(k + 32), 8'(k + 16), 8'(k)});
        end
        check("R9 empty after draining words", 32'(flag_empty), 32'd1);

        // ---- R4 R6 R7 R11: byte mode on lane 0
        do_clear(1'b0);
        for (int k = 1; k <= 16; k++) begin
            step(1'b0, A_WB, {24'hFFFFFF, 8'(8'hC0 + k)}, 8'h0);
            check($sformatf("R7 byte half after %0d", k), 32'(flag_half), 32'(k >= 8));
            check($sformatf("R6 byte full after %0d", k), 32'(flag_full), 32'(k == 16));
            check($sformatf("R8 no word avail in byte mode %0d", k),
                  32'(flag_word_avail), 32'd0);
        end
        step(1'b0, A_WB, 32'h000000AA, 8'h0);
        check("R4 17th byte push refused", 32'(err_access), 32'd1);
        step(1'b0, A_RW, 32'h0, 8'h0);
        check("R11 word pop in byte mode refused", 32'(err_access), 32'd1);
        for (int k = 1; k <= 16; k++) begin
            step(1'b0, A_RB, 32'h0, 8'h0);
            check($sformatf("R4 byte %0d data", k), cap_rd, {24'h0, 8'(8'hC0 + k)});
        end
        check("R4 empty after draining bytes", 32'(flag_empty), 32'd1);

        // ---- R1: soft clear discards stored words
        do_clear(1'b1);
        step(1'b1, A_WW, 32'h01020304, 8'h0);
        step(1'b1, A_WW, 32'h05060708, 8'h0);
        do_clear(1'b1);
        check("R1 soft clear flags", 32'(flag_vec()), 32'(6'b001000));
        step(1'b1, A_RW, 32'h0, 8'h0);
        check("R1 nothing left after clear", 32'(err_access), 32'd1);
        step(1'b1, A_WW, 32'h0A0B0C0D, 8'h0);
        step(1'b1, A_SO, 32'h0, 8'h0);
        check("R1 rotation restarts at lane 0", 32'(cap_sh), 32'h0D);

        // ---- R12: push and pop conflicts
        do_clear(1'b1);
        step(1'b1, A_WW | A_SP, 32'hCAFEF00D, 8'h55);
        check("R12 push conflict error", 32'(err_access), 32'd1);
        step(1'b1, A_RW, 32'h0, 8'h0);
        check("R12 bus push kept", cap_rd, 32'hCAFEF00D);
        check("R12 shifter push dropped", 32'(flag_empty), 32'd1);
        step(1'b1, A_WW, 32'h11223344, 8'h0);
        step(1'b1, A_RW | A_SO, 32'h0, 8'h0);
        check("R12 pop conflict error", 32'(err_access), 32'd1);
        check("R12 bus pop kept", cap_rd, 32'h11223344);
        check("R12 shifter pop dropped", 32'(flag_empty), 32'd1);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule